// File: doc/BRIEF.md
# Paged Switch Register Access Bridge

This block lets a controller read or write one 32-bit register of an on-chip switch when the only path to it is a 16-bit management bus. It takes one request and turns it into three management transactions. The first writes a page value that holds the upper address bits. The next two move the two 16-bit halves of the word. Each transaction goes to a downstream management master through a request and done handshake. That master owns the wire protocol.

The `variant_b` input picks one of two address translations, which differ in the page target and in how the page value is formed. A read fetches the low half before the high half. A write sends the high half first, except at one register (switch address 0x98), where the switch requires the low half first. When both halves have been moved, the bridge pulses `done` and returns read data. If any step fails, the sequence stops at once and `err` is raised with `done`.

Top module: `swreg_mdio_bridge`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `err` and `md_req` are 0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from acceptance until `done`. A `req_valid` raised while busy is dropped and issues no transaction.
- R3: Every sequence opens with a management write to the page target. With `variant_b`=0 the target is PHY 0x1f, register 0x10, and the data is the address shifted right by 9, cut to 16 bits.
- R4: With `variant_b`=0 the halves go to PHY ((addr>>6)&7)|0x10. The low half uses register (addr>>1)&0x1e and the high half uses that register with bit 0 set.
- R5: With `variant_b`=1 the page write goes to PHY 0x18, register 0x00, with data (addr>>9)&0x1ff.
- R6: With `variant_b`=1, take w=(addr&~3)>>1. The low half goes to PHY ((w>>5)&7)|0x10, register w&0x1f. The high half uses the same formulas with w+1.
- R7: A read issues two management reads, the low half then the high half. `rdata` becomes {high,low}.
- R8: A write issues two management writes, high half (`req_wdata[31:16]`) first, then low half (`req_wdata[15:0]`).
- R9: A write to switch address 0x98 sends the low half first and the high half second, in either variant.
- R10: A management response with `md_err`=1 ends the sequence. `done` and `err` rise together on the next cycle, and no further transaction is issued.
- R11: `done` is high for exactly one cycle per accepted request. `rdata` changes only during a read sequence, so it holds from `done` until a later read and a write leaves it untouched.
- R12: `md_req` and its target, direction and data stay steady until `md_done` answers them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Switch register byte address |
| req_wdata | input | 32 | Write data |
| variant_b | input | 1 | Address translation select |
| req_ready | output | 1 | Bridge idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sequence aborted, valid with done |
| rdata | output | 32 | Assembled read data |
| md_req | output | 1 | Management transaction request |
| md_write | output | 1 | Management transaction is a write |
| md_phy | output | 5 | Management PHY address |
| md_reg | output | 5 | Management register address |
| md_wdata | output | 16 | Management write data |
| md_done | input | 1 | Management transaction complete |
| md_err | input | 1 | Management transaction failed |
| md_rdata | input | 16 | Management read data |

## Verification
The bench builds the bridge with ADDR_W=20, so addresses can carry bits above bit 17. There the variant-A page value (up to 11 bits) and the variant-B page value (masked to 9 bits) differ, which exposes a wrong mask or page target. The downstream master is modelled with a response latency and an error injected at a chosen step. This reaches the abort on the page write and on a half access, and also the swapped ordering at address 0x98 in both variants.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PAGE   = 2'd1,
    ST_FIRST  = 2'd2,
    ST_SECOND = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regn;
  } md_tgt_t;
endpackage

// File: rtl/swreg_addr_map.sv
module swreg_addr_map
  import swreg_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              var_b,
  input  logic [ADDR_W-1:0] addr,
  output md_tgt_t           page_tgt,
  output logic [HALF_W-1:0] page_data,
  output md_tgt_t           lo_tgt,
  output md_tgt_t           hi_tgt
);
  logic [ADDR_W-1:0] widx;
  logic [ADDR_W-1:0] widx_p1;

  assign widx    = (addr & ~ADDR_W'(3)) >> 1;
  assign widx_p1 = widx + ADDR_W'(1);

  always_comb begin
    if (var_b) begin
      page_tgt.phy  = 5'h18;
      page_tgt.regn = 5'h00;
      page_data     = HALF_W'((addr >> 9) & ADDR_W'('h1ff));
      lo_tgt.phy    = PHY_W'(((widx >> 5) & ADDR_W'(7)) | ADDR_W'('h10));
      lo_tgt.regn   = REG_W'(widx & ADDR_W'('h1f));
      hi_tgt.phy    = PHY_W'(((widx_p1 >> 5) & ADDR_W'(7)) | ADDR_W'('h10));
      hi_tgt.regn   = REG_W'(widx_p1 & ADDR_W'('h1f));
    end else begin
      page_tgt.phy  = 5'h1f;
      page_tgt.regn = 5'h10;
      page_data     = HALF_W'(addr >> 9);
      lo_tgt.phy    = PHY_W'(((addr >> 6) & ADDR_W'(7)) | ADDR_W'('h10));
      lo_tgt.regn   = REG_W'((addr >> 1) & ADDR_W'('h1e));
      hi_tgt.phy    = lo_tgt.phy;
      hi_tgt.regn   = lo_tgt.regn | REG_W'(1);
    end
  end
endmodule

// File: rtl/swreg_seq.sv
module swreg_seq
  import swreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic              lo_first,
  input  md_tgt_t           page_tgt,
  input  logic [HALF_W-1:0] page_data,
  input  md_tgt_t           lo_tgt,
  input  md_tgt_t           hi_tgt,
  input  logic [WORD_W-1:0] wdata,
  output logic              ready,
  output logic              md_req,
  output logic              md_write,
  output logic [PHY_W-1:0]  md_phy,
  output logic [REG_W-1:0]  md_reg,
  output logic [HALF_W-1:0] md_wdata,
  input  logic              md_done,
  input  logic              md_err,
  input  logic [HALF_W-1:0] md_rdata,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] rdata
);
  seq_st_t           st_q, st_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [WORD_W-1:0] rdata_q;
  logic              first_lo;
  logic              cur_lo;
  logic              busy;
  logic              cap_en;
  md_tgt_t           tgt;

  assign busy     = (st_q != ST_IDLE);
  assign first_lo = !wr || lo_first;
  assign cur_lo   = (st_q == ST_FIRST) ? first_lo : !first_lo;

  always_comb begin
    if (st_q == ST_PAGE) begin
      tgt      = page_tgt;
      md_wdata = page_data;
      md_write = 1'b1;
    end else begin
      tgt      = cur_lo ? lo_tgt : hi_tgt;
      md_wdata = cur_lo ? wdata[HALF_W-1:0] : wdata[WORD_W-1:HALF_W];
      md_write = wr;
    end
  end

  assign md_req = busy;
  assign md_phy = tgt.phy;
  assign md_reg = tgt.regn;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_PAGE;
      default: begin
        if (md_done) begin
          if (md_err) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            case (st_q)
              ST_PAGE:  st_d = ST_FIRST;
              ST_FIRST: st_d = ST_SECOND;
              default: begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
              end
            endcase
          end
        end
      end
    endcase
  end

  assign cap_en = busy && (st_q != ST_PAGE) && md_done && !md_err && !wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      if (cur_lo) rdata_q[HALF_W-1:0]      <= md_rdata;
      else        rdata_q[WORD_W-1:HALF_W] <= md_rdata;
    end
  end

  assign ready = !busy;
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !md_req); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (md_req && !md_done) |=> (md_req && $stable(md_phy) && $stable(md_reg)
                              && $stable(md_write) && $stable(md_wdata))); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R10
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (md_req && md_done && md_err) |=> (!md_req && done && err)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable(rdata)); // R11
endmodule

// File: rtl/swreg_mdio_bridge.sv
module swreg_mdio_bridge
  import swreg_pkg::*;
#(
  parameter int          ADDR_W         = 20,
  parameter logic [31:0] LOW_FIRST_ADDR = 32'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              variant_b,
  output logic              req_ready,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              md_req,
  output logic              md_write,
  output logic [4:0]        md_phy,
  output logic [4:0]        md_reg,
  output logic [15:0]       md_wdata,
  input  logic              md_done,
  input  logic              md_err,
  input  logic [15:0]       md_rdata
);
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic              varb_q;
  logic              lof_q;
  logic [WORD_W-1:0] wdata_q;
  md_tgt_t           page_tgt, lo_tgt, hi_tgt;
  logic [HALF_W-1:0] page_data;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      varb_q  <= 1'b0;
      lof_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      varb_q  <= variant_b;
      lof_q   <= (32'(req_addr) == LOW_FIRST_ADDR);
      wdata_q <= req_wdata;
    end
  end

  swreg_addr_map #(.ADDR_W(ADDR_W)) map_i (
    .var_b     (varb_q),
    .addr      (addr_q),
    .page_tgt  (page_tgt),
    .page_data (page_data),
    .lo_tgt    (lo_tgt),
    .hi_tgt    (hi_tgt)
  );

  swreg_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .wr        (wr_q),
    .lo_first  (lof_q),
    .page_tgt  (page_tgt),
    .page_data (page_data),
    .lo_tgt    (lo_tgt),
    .hi_tgt    (hi_tgt),
    .wdata     (wdata_q),
    .ready     (req_ready),
    .md_req    (md_req),
    .md_write  (md_write),
    .md_phy    (md_phy),
    .md_reg    (md_reg),
    .md_wdata  (md_wdata),
    .md_done   (md_done),
    .md_err    (md_err),
    .md_rdata  (md_rdata),
    .done      (done),
    .err       (err),
    .rdata     (rdata)
  );
endmodule

// File: tb/swreg_mdio_bridge_tb.sv
module swreg_mdio_bridge_tb_top;
  localparam int AW = 20;
  localparam int NV = 8;
  // vector: {variant_b, write, addr[19:0], wdata[31:0]}
  localparam logic [53:0] VEC [NV] = '{
    {1'b0, 1'b0, 20'h00010, 32'h0},
    {1'b0, 1'b1, 20'h00098, 32'h12345678},
    {1'b0, 1'b1, 20'h00040, 32'hCAFEF00D},
    {1'b1, 1'b0, 20'h0C0A4, 32'h0},
    {1'b1, 1'b1, 20'h00098, 32'hA5A55A5A},
    {1'b0, 1'b0, 20'hFFFFC, 32'h0},
    {1'b1, 1'b0, 20'hFFFFC, 32'h0},
    {1'b1, 1'b1, 20'h55A3C, 32'h0BADBEEF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          variant_b = 1'b0;
  logic          req_ready, done, err;
  logic [31:0]   rdata;
  logic          md_req, md_write;
  logic [4:0]    md_phy, md_reg;
  logic [15:0]   md_wdata;
  logic          md_done = 1'b0;
  logic          md_err = 1'b0;
  logic [15:0]   md_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  int step = 0;
  int err_step = -1;
  int lat = 1;
  int cnt = 0;
  logic [4:0]  lg_phy [4];
  logic [4:0]  lg_reg [4];
  logic        lg_wr  [4];
  logic [15:0] lg_dat [4];
  logic [4:0]  ex_phy [3];
  logic [4:0]  ex_reg [3];
  logic        ex_wr  [3];
  logic [15:0] ex_dat [3];
  logic [31:0] ex_rdata;
  logic        got_err;
  logic [31:0] got_rdata;

  always #4 clk = ~clk;

  swreg_mdio_bridge #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .variant_b(variant_b),
    .req_ready(req_ready), .done(done), .err(err), .rdata(rdata),
    .md_req(md_req), .md_write(md_write), .md_phy(md_phy), .md_reg(md_reg),
    .md_wdata(md_wdata), .md_done(md_done), .md_err(md_err), .md_rdata(md_rdata)
  );

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h2b};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // downstream management master model
  initial begin
    forever begin
      @(negedge clk);
      md_done = 1'b0;
      md_err  = 1'b0;
      if (md_req) begin
        if (cnt >= lat) begin
          if (step < 4) begin
            lg_phy[step] = md_phy;
            lg_reg[step] = md_reg;
            lg_wr[step]  = md_write;
            lg_dat[step] = md_wdata;
          end
          md_done  = 1'b1;
          md_err   = (step == err_step);
          md_rdata = resp(md_phy, md_reg);
          step++;
          cnt = 0;
        end else begin
          cnt++;
        end
      end
    end
  end

  // reference model of the translation and ordering
  task automatic build_exp(input logic vb, input logic wr, input logic [AW-1:0] a,
                           input logic [31:0] wd);
    logic [31:0] a32, w, w1;
    logic [4:0] lp, lr, hp, hr;
    a32 = 32'(a);
    if (!vb) begin
      ex_phy[0] = 5'h1f; ex_reg[0] = 5'h10; ex_dat[0] = 16'(a32 >> 9);        // R3
      lp = 5'(((a32 >> 6) & 7) | 'h10); lr = 5'((a32 >> 1) & 'h1e);          // R4
      hp = lp; hr = lr | 5'd1;
    end else begin
      ex_phy[0] = 5'h18; ex_reg[0] = 5'h00; ex_dat[0] = 16'((a32 >> 9) & 'h1ff); // R5
      w  = (a32 & ~32'd3) >> 1;                                                // R6
      w1 = w + 1;
      lp = 5'(((w >> 5) & 7) | 'h10);  lr = 5'(w & 'h1f);
      hp = 5'(((w1 >> 5) & 7) | 'h10); hr = 5'(w1 & 'h1f);
    end
    ex_wr[0] = 1'b1;
    ex_wr[1] = wr; ex_wr[2] = wr;
    if (!wr || a32 == 32'h98) begin   // R7 low first on reads, R9 low first at 0x98
      ex_phy[1] = lp; ex_reg[1] = lr; ex_dat[1] = wd[15:0];
      ex_phy[2] = hp; ex_reg[2] = hr; ex_dat[2] = wd[31:16];
    end else begin                    // R8 high first
      ex_phy[1] = hp; ex_reg[1] = hr; ex_dat[1] = wd[31:16];
      ex_phy[2] = lp; ex_reg[2] = lr; ex_dat[2] = wd[15:0];
    end
    ex_rdata = {resp(hp, hr), resp(lp, lr)};
  endtask

  task automatic run_req(input logic vb, input logic wr, input logic [AW-1:0] a,
                         input logic [31:0] wd, input int estep, input bit poke_busy);
    int t;
    step = 0; cnt = 0; err_step = estep;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; variant_b = vb; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready low after accept", 32'(req_ready), 0);
    if (poke_busy) begin
      req_valid = 1'b1; req_addr = 20'h3ABCD; req_write = ~wr; variant_b = ~vb;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R11", "done seen", 32'(done), 1);
    got_err = err;
    got_rdata = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", 32'(done), 0);
  endtask

  task automatic check_log(input string rq, input int n);
    for (int i = 0; i < n; i++) begin
      chk(lg_phy[i] == ex_phy[i], rq, $sformatf("step%0d phy", i), 32'(lg_phy[i]), 32'(ex_phy[i]));
      chk(lg_reg[i] == ex_reg[i], rq, $sformatf("step%0d reg", i), 32'(lg_reg[i]), 32'(ex_reg[i]));
      chk(lg_wr[i] == ex_wr[i], rq, $sformatf("step%0d dir", i), 32'(lg_wr[i]), 32'(ex_wr[i]));
      if (ex_wr[i])
        chk(lg_dat[i] == ex_dat[i], rq, $sformatf("step%0d data", i), 32'(lg_dat[i]), 32'(ex_dat[i]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready", 32'(req_ready), 1);
    chk(done == 1'b0, "R1", "done", 32'(done), 0);
    chk(err == 1'b0, "R1", "err", 32'(err), 0);
    chk(md_req == 1'b0, "R1", "md_req", 32'(md_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      lat = v % 3;
      build_exp(VEC[v][53], VEC[v][52], VEC[v][51:32], VEC[v][31:0]);
      run_req(VEC[v][53], VEC[v][52], VEC[v][51:32], VEC[v][31:0], -1, 1'b0);
      chk(step == 3, "R3", "transaction count", 32'(step), 3);
      check_log(VEC[v][53] ? "R5/R6 order R7-R9" : "R3/R4 order R7-R9", 3);
      chk(got_err == 1'b0, "R10", "no error", 32'(got_err), 0);
      if (!VEC[v][52])
        chk(got_rdata == ex_rdata, "R7", "read data", got_rdata, ex_rdata);
    end

    // R2: request raised while busy is dropped
    lat = 2;
    build_exp(1'b0, 1'b0, 20'h00204, 32'h0);
    run_req(1'b0, 1'b0, 20'h00204, 32'h0, -1, 1'b1);
    repeat (4) @(negedge clk);
    chk(step == 3, "R2", "busy request ignored", 32'(step), 3);
    check_log("R2", 3);
    chk(md_req == 1'b0 && req_ready == 1'b1, "R2", "still idle", 32'(md_req), 0);

    // R11: rdata held, write leaves it untouched
    held = rdata;
    build_exp(1'b1, 1'b1, 20'h00300, 32'hFFFF0000);
    run_req(1'b1, 1'b1, 20'h00300, 32'hFFFF0000, -1, 1'b0);
    chk(rdata == held, "R11", "rdata kept over write", rdata, held);

    // R10: abort on page write
    lat = 1;
    run_req(1'b0, 1'b1, 20'h00100, 32'h11112222, 0, 1'b0);
    chk(got_err == 1'b1, "R10", "err on page", 32'(got_err), 1);
    repeat (4) @(negedge clk);
    chk(step == 1, "R10", "no step after page error", 32'(step), 1);

    // R10: abort on second half of a read
    run_req(1'b1, 1'b0, 20'h00400, 32'h0, 2, 1'b0);
    chk(got_err == 1'b1, "R10", "err on second half", 32'(got_err), 1);
    repeat (4) @(negedge clk);
    chk(step == 3 && md_req == 1'b0, "R10", "idle after abort", 32'(step), 3);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule